// File: doc/BRIEF.md
# Multithreaded In-Order Issue Scheduler

This block decides, every clock cycle, which hardware thread contexts of a multithreaded in-order core may send instructions to execution. A shared pool of 2048 architectural registers is split evenly among the contexts. A two-bit configuration input picks the per-thread register allocation, and that choice fixes how many contexts are live. Each cycle the scheduler fills up to three issue slots with distinct live threads. A thread qualifies only when it is ready and has at least one instruction waiting. Each granted thread may send one or two of its next instructions in program order.

Threads are granted in round-robin order. The search starts at the thread that follows the last one granted in the previous cycle, so no ready thread is passed over forever. With each grant the block also reports where that thread's register window begins in the shared pool. Decoding, hazard checks and execution belong to other blocks.

Top module: `issue_sched`

## Requirements
- R1: After reset the round-robin search starts at thread 0.
- R2: Configuration code 0 (and reserved code 3) gives 256 registers per thread and 8 live threads. Code 1 gives 128 registers and code 2 gives 64 registers; each of these would allow 2048/size threads but is capped at MAX_CTX (16), so both give 16 live threads. A thread whose ID is at or above the live count is never granted, whatever its inputs.
- R3: A thread is granted only if its ready bit is 1 and its 2-bit available count (bits [2i+1:2i] of `thr_avail`) is nonzero.
- R4: Slots fill in order from slot 0. An unused slot has its valid bit low and drives zero on its ID, count and base.
- R5: No thread ID appears in two valid slots in the same cycle.
- R6: A slot's issue count is the smaller of 2 and the thread's available count, so an available code of 3 issues 2.
- R7: Within a cycle, slots take eligible threads in ascending ID order, wrapping from the highest ID to 0. The search starts just after the pointer. The pointer becomes the ID in the last valid slot of the cycle and holds when nothing is granted.
- R8: A slot's register base equals its thread ID times the registers-per-thread value of the active configuration.
- R9: When fewer threads are eligible than there are slots, exactly the eligible ones are granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| regs_sel | input | 2 | Registers-per-thread code: 0=256, 1=128, 2=64, 3=256 |
| thr_ready | input | 16 | Per-thread ready flag, bit i for thread i |
| thr_avail | input | 32 | Per-thread available instruction count, 2 bits per thread |
| slot_vld | output | 3 | Per-slot grant valid |
| slot_tid | output | 12 | Per-slot thread ID, 4 bits per slot, slot 0 lowest |
| slot_cnt | output | 6 | Per-slot issue count, 2 bits per slot |
| slot_base | output | 33 | Per-slot register window base, 11 bits per slot |

## Verification
The first pattern makes every thread eligible under each configuration. It shows that the live-count cap stops the rotation at the right ID and that the wrap and the pointer advance follow the last slot. Sparse ready masks separate a correct wrap past the top ID from a scan that restarts at zero. A single eligible thread, or none at all, shows whether the pointer holds and whether unused slots stay clear. Mixed available counts, including the code 3, separate count clamping from plain forwarding. Running the same pattern under different codes shows that the register bases scale with the configuration.

// File: rtl/issue_sched_pkg.sv
// Shared definitions for the issue scheduler.
// Assumes the pool size and the allocation sizes are powers of two.
package issue_sched_pkg;

    typedef enum logic [1:0] {
        RPT_256 = 2'd0,
        RPT_128 = 2'd1,
        RPT_64  = 2'd2,
        RPT_RSV = 2'd3
    } rpt_sel_e;

    // Map a configuration code to its registers-per-thread value.
    function automatic int rpt_of(input rpt_sel_e sel);
        case (sel)
            RPT_128: rpt_of = 128;
            RPT_64:  rpt_of = 64;
            default: rpt_of = 256;
        endcase
    endfunction

endpackage

// File: rtl/sched_cfg.sv
// Turns the allocation code into registers-per-thread and a live-thread count.
// Assumes POOL_REGS is divisible by every allocation size.
module sched_cfg
    import issue_sched_pkg::*;
#(
    parameter int MAX_CTX   = 16,
    parameter int POOL_REGS = 2048,
    localparam int TID_W    = $clog2(MAX_CTX),
    localparam int BASE_W   = $clog2(POOL_REGS)
) (
    input  logic [1:0]        sel_i,
    output logic [TID_W:0]    active_o,
    output logic [BASE_W-1:0] rpt_o
);

    // Divide the pool by the allocation and cap the result at the context count.
    always_comb begin
        int r;
        int a;
        r = rpt_of(rpt_sel_e'(sel_i));
        a = POOL_REGS / r;
        if (a > MAX_CTX) a = MAX_CTX;
        rpt_o    = BASE_W'(r);
        active_o = (TID_W+1)'(a);
    end

endmodule

// File: rtl/sched_select.sv
// Round-robin pick of up to NUM_SLOTS distinct eligible threads.
// The search starts at ptr_i+1 and wraps. Assumes MAX_CTX is a power of two.
module sched_select #(
    parameter int MAX_CTX   = 16,
    parameter int NUM_SLOTS = 3,
    localparam int TID_W    = $clog2(MAX_CTX)
) (
    input  logic [TID_W-1:0]   ptr_i,
    input  logic [MAX_CTX-1:0] elig_i,
    output logic               vld_o [NUM_SLOTS],
    output logic [TID_W-1:0]   tid_o [NUM_SLOTS]
);

    // Each slot takes the first eligible thread in rotated order that no earlier slot took.
    always_comb begin
        logic [MAX_CTX-1:0] taken;
        logic [TID_W-1:0]   idx;
        taken = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            vld_o[s] = 1'b0;
            tid_o[s] = '0;
            for (int off = 1; off <= MAX_CTX; off++) begin
                idx = TID_W'(32'(ptr_i) + off);
                if (!vld_o[s] && elig_i[idx] && !taken[idx]) begin
                    vld_o[s] = 1'b1;
                    tid_o[s] = idx;
                end
            end
            if (vld_o[s]) taken[tid_o[s]] = 1'b1;
        end
    end

endmodule

// File: rtl/sched_rrptr.sv
// Holds the round-robin pointer: the thread granted last in the previous cycle.
// Reset points at the top ID so that the first search begins at thread 0.
module sched_rrptr #(
    parameter int MAX_CTX   = 16,
    parameter int NUM_SLOTS = 3,
    localparam int TID_W    = $clog2(MAX_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i [NUM_SLOTS],
    input  logic [TID_W-1:0] tid_i [NUM_SLOTS],
    output logic [TID_W-1:0] ptr_o
);

    logic             any_grant;
    logic [TID_W-1:0] last_tid;

    // Find the ID in the highest valid slot.
    always_comb begin
        any_grant = 1'b0;
        last_tid  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (vld_i[s]) begin
                any_grant = 1'b1;
                last_tid  = tid_i[s];
            end
        end
    end

    // Advance on any grant, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_o <= TID_W'(MAX_CTX - 1);
        else if (any_grant) ptr_o <= last_tid;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_grant |=> ptr_o == $past(ptr_o)); // R7

endmodule

// File: rtl/issue_sched.sv
// Issue scheduler top: qualifies threads, picks up to NUM_SLOTS of them in
// round-robin order, and reports the issue count and register base for each.
// Assumes the per-thread available count arrives in 2-bit fields.
module issue_sched #(
    parameter int MAX_CTX   = 16,
    parameter int NUM_SLOTS = 3,
    parameter int POOL_REGS = 2048,
    parameter int ISSUE_MAX = 2,
    localparam int TID_W    = $clog2(MAX_CTX),
    localparam int BASE_W   = $clog2(POOL_REGS),
    localparam int CNT_W    = $clog2(ISSUE_MAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  regs_sel,
    input  logic [MAX_CTX-1:0]          thr_ready,
    input  logic [MAX_CTX*CNT_W-1:0]    thr_avail,
    output logic [NUM_SLOTS-1:0]        slot_vld,
    output logic [NUM_SLOTS*TID_W-1:0]  slot_tid,
    output logic [NUM_SLOTS*CNT_W-1:0]  slot_cnt,
    output logic [NUM_SLOTS*BASE_W-1:0] slot_base
);

    localparam int ACT_W = TID_W + 1;

    logic [ACT_W-1:0]   active;
    logic [BASE_W-1:0]  rpt;
    logic [MAX_CTX-1:0] elig;
    logic [TID_W-1:0]   ptr;
    logic               vld_a [NUM_SLOTS];
    logic [TID_W-1:0]   tid_a [NUM_SLOTS];

    sched_cfg #(.MAX_CTX(MAX_CTX), .POOL_REGS(POOL_REGS)) u_cfg (
        .sel_i(regs_sel), .active_o(active), .rpt_o(rpt)
    );

    // A thread qualifies when ready, holding work, and inside the live range.
    for (genvar i = 0; i < MAX_CTX; i++) begin : g_elig
        assign elig[i] = thr_ready[i] && (thr_avail[i*CNT_W +: CNT_W] != '0)
                         && (ACT_W'(i) < active);
    end

    sched_select #(.MAX_CTX(MAX_CTX), .NUM_SLOTS(NUM_SLOTS)) u_sel (
        .ptr_i(ptr), .elig_i(elig), .vld_o(vld_a), .tid_o(tid_a)
    );

    sched_rrptr #(.MAX_CTX(MAX_CTX), .NUM_SLOTS(NUM_SLOTS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_a), .tid_i(tid_a), .ptr_o(ptr)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [CNT_W-1:0] av;
        assign av = thr_avail[tid_a[s]*CNT_W +: CNT_W];

        // Drive the slot outputs, clamping the count and scaling the base.
        always_comb begin
            slot_vld[s] = vld_a[s];
            slot_tid[s*TID_W +: TID_W] = vld_a[s] ? tid_a[s] : '0;
            slot_cnt[s*CNT_W +: CNT_W] = !vld_a[s] ? '0 :
                (av > CNT_W'(ISSUE_MAX)) ? CNT_W'(ISSUE_MAX) : av;
            slot_base[s*BASE_W +: BASE_W] = vld_a[s] ?
                BASE_W'(32'(tid_a[s]) * 32'(rpt)) : '0;
        end

        AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[s] |-> thr_ready[slot_tid[s*TID_W +: TID_W]] && (slot_cnt[s*CNT_W +: CNT_W] != '0)); // R3
        AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[s] |-> ACT_W'(slot_tid[s*TID_W +: TID_W]) < active); // R2
        AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[s] |-> slot_cnt[s*CNT_W +: CNT_W] <= CNT_W'(ISSUE_MAX)); // R6
        if (s > 0) begin : g_pack
            AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[s] |-> slot_vld[s-1]); // R4
        end
        for (genvar t = s + 1; t < NUM_SLOTS; t++) begin : g_pair
            AST_SLOT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_vld[s] && slot_vld[t]) |->
                slot_tid[s*TID_W +: TID_W] != slot_tid[t*TID_W +: TID_W]); // R5
        end
    end

endmodule

// File: tb/issue_sched_test.sv
// Bench for issue_sched: walks a vector table, then applies directed reset checks.
module issue_sched_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  regs_sel = 2'd0;
    logic [15:0] thr_ready = '0;
    logic [31:0] thr_avail = '0;
    logic [2:0]  slot_vld;
    logic [11:0] slot_tid;
    logic [5:0]  slot_cnt;
    logic [32:0] slot_base;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    issue_sched uut (
        .clk(clk), .rst_n(rst_n), .regs_sel(regs_sel), .thr_ready(thr_ready),
        .thr_avail(thr_avail), .slot_vld(slot_vld), .slot_tid(slot_tid),
        .slot_cnt(slot_cnt), .slot_base(slot_base)
    );

    typedef struct packed {
        logic [1:0]  cfg;
        logic [15:0] rdy;
        logic [31:0] av;
        logic [2:0]  vld;
        logic [11:0] tids;   // {slot2, slot1, slot0}
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd0, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd2,  4'd1,  4'd0}},  // R1 R7
        '{2'd0, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd5,  4'd4,  4'd3}},  // R7
        '{2'd0, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd0,  4'd7,  4'd6}},  // R2 wrap at 8
        '{2'd1, 16'hFFFF, 32'h55555555, 3'b111, {4'd3,  4'd2,  4'd1}},  // R6 count 1
        '{2'd1, 16'h8001, 32'hAAAAAAAA, 3'b011, {4'd0,  4'd0,  4'd15}}, // R9 wrap at 16
        '{2'd1, 16'hFFFF, 32'h000C0400, 3'b011, {4'd0,  4'd9,  4'd5}},  // R3 R6 code 3
        '{2'd1, 16'h0000, 32'hAAAAAAAA, 3'b000, {4'd0,  4'd0,  4'd0}},  // R4 none
        '{2'd2, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd12, 4'd11, 4'd10}}, // R7 held, R8
        '{2'd3, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd2,  4'd1,  4'd0}},  // R2 reserved
        '{2'd2, 16'hFFFF, 32'hAAAAAAAA, 3'b111, {4'd5,  4'd4,  4'd3}}   // R8 64 regs
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rpt_exp(input logic [1:0] c);
        case (c)
            2'd1:    rpt_exp = 128;
            2'd2:    rpt_exp = 64;
            default: rpt_exp = 256;
        endcase
    endfunction

    // Compare all slots against the expected valids and IDs; counts and bases follow R6, R8.
    task automatic check_slots(input logic [1:0] c, input logic [31:0] av,
                               input logic [2:0] ev, input logic [11:0] et);
        chk("R4 valid", int'(slot_vld), int'(ev));
        for (int s = 0; s < 3; s++) begin
            int t;
            int a;
            t = int'(et[s*4 +: 4]);
            a = int'(av[t*2 +: 2]);
            if (ev[s]) begin
                chk("R7 tid", int'(slot_tid[s*4 +: 4]), t);
                chk("R6 count", int'(slot_cnt[s*2 +: 2]), (a > 2) ? 2 : a);
                chk("R8 base", int'(slot_base[s*11 +: 11]), t * rpt_exp(c));
            end else begin
                chk("R4 unused tid", int'(slot_tid[s*4 +: 4]), 0);
                chk("R4 unused count", int'(slot_cnt[s*2 +: 2]), 0);
            end
        end
        if (slot_vld[0] && slot_vld[1])
            chk("R5 distinct", int'(slot_tid[3:0] != slot_tid[7:4]), 1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R4 reset idle", int'(slot_vld), 0);

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            regs_sel  = TBL[i].cfg;
            thr_ready = TBL[i].rdy;
            thr_avail = TBL[i].av;
            #2;
            check_slots(TBL[i].cfg, TBL[i].av, TBL[i].vld, TBL[i].tids);
        end

        // R1: reset mid-run returns the search start to thread 0.
        @(negedge clk);
        rst_n = 1'b0;
        thr_ready = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        regs_sel  = 2'd1;
        thr_ready = 16'hFFFF;
        thr_avail = 32'hAAAAAAAA;
        #2;
        check_slots(2'd1, 32'hAAAAAAAA, 3'b111, {4'd2, 4'd1, 4'd0});

        // R2: threads 8..15 ready alone under code 0 are never granted.
        @(negedge clk);
        regs_sel  = 2'd0;
        thr_ready = 16'hFF00;
        #2;
        chk("R2 out of range", int'(slot_vld), 0);

        // R9: one eligible thread gives exactly one slot.
        @(negedge clk);
        thr_ready = 16'h0010;
        #2;
        check_slots(2'd0, 32'hAAAAAAAA, 3'b001, {4'd0, 4'd0, 4'd4});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule